// File: doc/BRIEF.md
# PCI Function Slot and Event Queue Manager

This block tracks the PCI functions attached behind a host bridge and keeps the service events that firmware has not yet read. Each slot in the table is empty or occupied. An occupied slot has a function id, a function handle and a configured flag. A hot-plug or hot-unplug notice updates one slot. In the same cycle it queues the availability events that describe the state change, in a fixed order. Configure and deconfigure commands name a function by its id, and the block answers each one with a response code one cycle later.

Other logic files error events through a separate request port. Error events and availability events share one first-in first-out queue. A reader pops events one at a time. It sees a have-event flag, and each pop is acknowledged with a status and the event record. A notify pulse tells the channel-report side that at least one event was queued. A combinational index port returns the n-th occupied slot in slot-number order.

Top module: `pci_func_evt_mgr`

## Requirements
- R1: After reset all slots are empty and the queue is empty. have_event, q_overflow, evt_notify, pop_ack and rsp_vld are 0, and idx_found is 0 for every index.
- R2: A hot-plug of slot s sets its function id to s and its handle to s with bit 31 set, and marks it configured. The new state is visible on the index port from the next cycle.
- R3: A hot-plug queues two availability events (code 2) carrying the slot's handle and id. The first has qualifier 16'h0302 (reserved to standby) and the second has 16'h0301 (standby to configured).
- R4: An unplug of a configured slot queues qualifier 16'h0304 and then 16'h0308. An unplug of an unconfigured slot queues only 16'h0308. Both use the handle and id held before the unplug, and the slot then becomes empty with handle and id 0. When plug and unplug arrive together, the unplug is ignored.
- R5: The index port returns the idx_sel-th occupied slot, counting from 0 in ascending slot order, with its id, handle and configured flag. Past the last occupied slot, idx_found is 0 and the fields are 0.
- R6: A command (cmd_cfg 1 = configure, 0 = deconfigure) is answered one cycle later with a rsp_vld pulse. rsp_code 2 means no occupied slot has that id. rsp_code 1 means the slot is already in the requested state, and the state is unchanged. rsp_code 0 means the flag was toggled.
- R7: Events leave in arrival order. Within one cycle, the plug or unplug events are queued before a simultaneous error event (code 1).
- R8: pop_ack pulses one cycle after pop_req. If the queue was non-empty before that edge, pop_status is 0 and the head record is returned and removed. Otherwise pop_status is 1 and every field is 0.
- R9: An error record returns its qualifier, handle, id, 64-bit address and 32-bit detail unchanged. An availability record returns address and detail as 0.
- R10: The queue holds 16 events. Room is judged from the count held before the edge, in per-event order. An event with no room is dropped and sets q_overflow, which stays set until reset.
- R11: evt_notify is high for the one cycle after every cycle in which at least one event was queued. have_event is 1 exactly when the queue holds an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| plug_vld | input | 1 | Hot-plug notice |
| plug_slot | input | 5 | Slot being plugged |
| unplug_vld | input | 1 | Hot-unplug notice |
| unplug_slot | input | 5 | Slot being unplugged |
| cmd_vld | input | 1 | Configure/deconfigure command |
| cmd_cfg | input | 1 | 1 configure, 0 deconfigure |
| cmd_fid | input | 32 | Function id named by the command |
| rsp_vld | output | 1 | Command response pulse |
| rsp_code | output | 2 | 0 done, 1 no action, 2 id unknown |
| err_vld | input | 1 | Error event request |
| err_qual | input | 16 | Error qualifier code |
| err_fh | input | 32 | Error function handle |
| err_fid | input | 32 | Error function id |
| err_addr | input | 64 | Faulting address |
| err_detail | input | 32 | Error detail word |
| idx_sel | input | 6 | Index of occupied slot to look up |
| idx_found | output | 1 | Index names an occupied slot |
| idx_fid | output | 32 | Function id at that index |
| idx_fh | output | 32 | Function handle at that index |
| idx_cfg | output | 1 | Configured flag at that index |
| pop_req | input | 1 | Request to pop one event |
| pop_ack | output | 1 | Pop answer pulse |
| pop_status | output | 1 | 0 event returned, 1 queue was empty |
| ev_code | output | 2 | 1 error, 2 availability |
| ev_qual | output | 16 | Event qualifier |
| ev_fh | output | 32 | Event function handle |
| ev_fid | output | 32 | Event function id |
| ev_addr | output | 64 | Event address (error only) |
| ev_detail | output | 32 | Event detail (error only) |
| have_event | output | 1 | Queue not empty |
| evt_notify | output | 1 | One-cycle pulse after any enqueue |
| q_overflow | output | 1 | Sticky event-drop flag |

## Verification
The hardest case is a cycle that queues up to three events into a nearly full queue. The plug or unplug pair and an error arrive together, a pop is also pending, and only some of the events fit. The stimulus reaches it by first filling the queue with back-to-back error requests. A random phase then mixes plugs, unplugs, errors and pops with a reader that pops only about half the time, so the count sits near the limit. A bench model judges room from the pre-edge count and predicts exactly which events survive.

// File: rtl/pfe_pkg.sv
// Shared record type and code values for the PCI function event manager.
package pfe_pkg;
    localparam int QUAL_W   = 16;
    localparam int ID_W     = 32;
    localparam int ADDR_W   = 64;
    localparam int DET_W    = 32;
    localparam int VIRT_BIT = 31;

    localparam logic [1:0] CODE_ERR   = 2'd1;
    localparam logic [1:0] CODE_AVAIL = 2'd2;

    localparam logic [1:0] RSP_DONE    = 2'd0;
    localparam logic [1:0] RSP_NOOP    = 2'd1;
    localparam logic [1:0] RSP_UNKNOWN = 2'd2;

    localparam logic [QUAL_W-1:0] Q_RSV_TO_STBY = 16'h0302;
    localparam logic [QUAL_W-1:0] Q_STBY_TO_CFG = 16'h0301;
    localparam logic [QUAL_W-1:0] Q_CFG_TO_STBY = 16'h0304;
    localparam logic [QUAL_W-1:0] Q_STBY_TO_RSV = 16'h0308;

    typedef struct packed {
        logic [1:0]        code;
        logic [QUAL_W-1:0] qual;
        logic [ID_W-1:0]   fh;
        logic [ID_W-1:0]   fid;
        logic [ADDR_W-1:0] addr;
        logic [DET_W-1:0]  detail;
    } ev_rec_t;
endpackage

// File: rtl/pfe_slot_table.sv
// Slot table: occupancy and configured flag per slot. The id and handle are
// derived from the slot number, so only two bits are stored per slot.
// Assumes one plug or unplug per cycle; plug wins over unplug.
// Produces up to two availability events per cycle, combinationally.
module pfe_slot_table
    import pfe_pkg::*;
#(
    parameter int NUM_SLOTS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 plug_vld,
    input  logic [$clog2(NUM_SLOTS)-1:0] plug_slot,
    input  logic                 unplug_vld,
    input  logic [$clog2(NUM_SLOTS)-1:0] unplug_slot,
    input  logic                 cmd_vld,
    input  logic                 cmd_cfg,
    input  logic [ID_W-1:0]      cmd_fid,
    output logic                 rsp_vld,
    output logic [1:0]           rsp_code,
    input  logic [$clog2(NUM_SLOTS):0] idx_sel,
    output logic                 idx_found,
    output logic [ID_W-1:0]      idx_fid,
    output logic [ID_W-1:0]      idx_fh,
    output logic                 idx_cfg,
    output logic [1:0]           ev_vld,
    output ev_rec_t [1:0]        ev_rec
);
    localparam int SW = $clog2(NUM_SLOTS);
    localparam int IW = SW + 1;

    logic [NUM_SLOTS-1:0] occ;
    logic [NUM_SLOTS-1:0] cfg;
    logic                 hit;
    logic [SW-1:0]        hit_idx;
    logic [SW-1:0]        sel_slot;
    logic                 up_go;

    function automatic logic [ID_W-1:0] fh_of(input logic [SW-1:0] s);
        logic [ID_W-1:0] h;
        h = ID_W'(s);
        h[VIRT_BIT] = 1'b1;
        return h;
    endfunction

    assign up_go = unplug_vld && !plug_vld;

    // Find the lowest occupied slot whose id equals the command id.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (occ[i] && cmd_fid == ID_W'(i)) begin
                hit     = 1'b1;
                hit_idx = SW'(i);
            end
        end
    end

    // Find the idx_sel-th occupied slot in ascending order.
    always_comb begin
        logic [IW-1:0] seen;
        seen      = '0;
        idx_found = 1'b0;
        sel_slot  = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (occ[i]) begin
                if (!idx_found && seen == idx_sel) begin
                    idx_found = 1'b1;
                    sel_slot  = SW'(i);
                end
                seen = seen + 1'b1;
            end
        end
    end

    assign idx_fid = idx_found ? ID_W'(sel_slot) : '0;
    assign idx_fh  = idx_found ? fh_of(sel_slot) : '0;
    assign idx_cfg = idx_found && cfg[sel_slot];

    // Build the availability events for a plug or an unplug, from pre-edge state.
    always_comb begin
        logic [ID_W-1:0] cur_fh;
        logic [ID_W-1:0] cur_fid;
        ev_vld  = 2'b00;
        ev_rec  = '0;
        cur_fh  = occ[unplug_slot] ? fh_of(unplug_slot) : '0;
        cur_fid = occ[unplug_slot] ? ID_W'(unplug_slot) : '0;
        if (plug_vld) begin
            ev_vld         = 2'b11;
            ev_rec[0].code = CODE_AVAIL;
            ev_rec[0].qual = Q_RSV_TO_STBY;
            ev_rec[0].fh   = fh_of(plug_slot);
            ev_rec[0].fid  = ID_W'(plug_slot);
            ev_rec[1]      = ev_rec[0];
            ev_rec[1].qual = Q_STBY_TO_CFG;
        end else if (up_go) begin
            ev_rec[0].code = CODE_AVAIL;
            ev_rec[0].fh   = cur_fh;
            ev_rec[0].fid  = cur_fid;
            ev_rec[1]      = ev_rec[0];
            if (cfg[unplug_slot]) begin
                ev_vld         = 2'b11;
                ev_rec[0].qual = Q_CFG_TO_STBY;
                ev_rec[1].qual = Q_STBY_TO_RSV;
            end else begin
                ev_vld         = 2'b01;
                ev_rec[0].qual = Q_STBY_TO_RSV;
            end
        end
    end

    // Serve commands, then apply plug or unplug (which override same-slot toggles).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ      <= '0;
            cfg      <= '0;
            rsp_vld  <= 1'b0;
            rsp_code <= RSP_DONE;
        end else begin
            rsp_vld <= cmd_vld;
            if (cmd_vld) begin
                if (!hit) begin
                    rsp_code <= RSP_UNKNOWN;
                end else if (cfg[hit_idx] == cmd_cfg) begin
                    rsp_code <= RSP_NOOP;
                end else begin
                    rsp_code     <= RSP_DONE;
                    cfg[hit_idx] <= cmd_cfg;
                end
            end
            if (plug_vld) begin
                occ[plug_slot] <= 1'b1;
                cfg[plug_slot] <= 1'b1;
            end else if (up_go) begin
                occ[unplug_slot] <= 1'b0;
                cfg[unplug_slot] <= 1'b0;
            end
        end
    end

    AST_PLUG_SETS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        plug_vld |=> occ[$past(plug_slot)] && cfg[$past(plug_slot)]); // R2
    AST_UNPLUG_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        up_go |=> !occ[$past(unplug_slot)] && !cfg[$past(unplug_slot)]); // R4
    AST_UNKNOWN_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld && rsp_code != RSP_DONE && !$past(plug_vld) && !$past(unplug_vld)
        |-> $stable(cfg)); // R6
    AST_INDEX_ONLY_OCCUPIED: assert property (@(posedge clk) disable iff (!rst_n)
        idx_found |-> occ[idx_fid[SW-1:0]]); // R5
endmodule

// File: rtl/pfe_event_queue.sv
// Event queue: first-in first-out store that accepts up to NW events per cycle
// in port order and releases one per pop request. Room is judged from the
// count before the edge. Assumes DEPTH is a power of two.
module pfe_event_queue
    import pfe_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NW    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NW-1:0]     in_vld,
    input  ev_rec_t [NW-1:0]  in_rec,
    input  logic              pop_req,
    output logic              pop_ack,
    output logic              pop_status,
    output ev_rec_t           out_rec,
    output logic              have_event,
    output logic              notify,
    output logic              overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    ev_rec_t         mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   cnt;
    logic [CW:0]     used;
    logic [NW-1:0]   acc;
    logic [AW-1:0]   widx [NW];
    logic            take;
    logic            drop;
    ev_rec_t         head_view;

    assign take       = pop_req && (cnt != '0);
    assign have_event = (cnt != '0);

    // Decide which incoming events fit and where each one lands.
    always_comb begin
        logic [AW-1:0] ofs;
        used = (CW + 1)'(cnt);
        ofs  = '0;
        acc  = '0;
        for (int k = 0; k < NW; k++) begin
            widx[k] = wr_ptr + ofs;
            if (in_vld[k] && used < (CW + 1)'(DEPTH)) begin
                acc[k] = 1'b1;
                used   = used + 1'b1;
                ofs    = ofs + 1'b1;
            end
        end
        drop = |(in_vld & ~acc);
    end

    // Present the head record with error-only fields cleared for other codes.
    always_comb begin
        head_view = mem[rd_ptr];
        if (head_view.code != CODE_ERR) begin
            head_view.addr   = '0;
            head_view.detail = '0;
        end
    end

    // Store accepted events.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NW; k++) begin
            if (acc[k]) mem[widx[k]] <= in_rec[k];
        end
    end

    // Pointers, count, pop answer, notify pulse and sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            cnt        <= '0;
            pop_ack    <= 1'b0;
            pop_status <= 1'b0;
            out_rec    <= '0;
            notify     <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            wr_ptr     <= wr_ptr + AW'(used - (CW + 1)'(cnt));
            rd_ptr     <= rd_ptr + AW'(take);
            cnt        <= CW'(used - (CW + 1)'(take));
            pop_ack    <= pop_req;
            pop_status <= pop_req && !take;
            out_rec    <= take ? head_view : '0;
            notify     <= |acc;
            overflow   <= overflow | drop;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R10
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R10
    AST_EMPTY_POP_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !have_event |=> pop_ack && pop_status && out_rec == '0); // R8
    AST_PUSH_NOTIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld[0] && !have_event |=> notify && have_event); // R11
endmodule

// File: rtl/pci_func_evt_mgr.sv
// Top of the PCI function event manager: slot table plus event queue.
// Queue write port order is plug/unplug event 0, event 1, then error event.
module pci_func_evt_mgr
    import pfe_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int Q_DEPTH   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         plug_vld,
    input  logic [$clog2(NUM_SLOTS)-1:0] plug_slot,
    input  logic                         unplug_vld,
    input  logic [$clog2(NUM_SLOTS)-1:0] unplug_slot,
    input  logic                         cmd_vld,
    input  logic                         cmd_cfg,
    input  logic [31:0]                  cmd_fid,
    output logic                         rsp_vld,
    output logic [1:0]                   rsp_code,
    input  logic                         err_vld,
    input  logic [15:0]                  err_qual,
    input  logic [31:0]                  err_fh,
    input  logic [31:0]                  err_fid,
    input  logic [63:0]                  err_addr,
    input  logic [31:0]                  err_detail,
    input  logic [$clog2(NUM_SLOTS):0]   idx_sel,
    output logic                         idx_found,
    output logic [31:0]                  idx_fid,
    output logic [31:0]                  idx_fh,
    output logic                         idx_cfg,
    input  logic                         pop_req,
    output logic                         pop_ack,
    output logic                         pop_status,
    output logic [1:0]                   ev_code,
    output logic [15:0]                  ev_qual,
    output logic [31:0]                  ev_fh,
    output logic [31:0]                  ev_fid,
    output logic [63:0]                  ev_addr,
    output logic [31:0]                  ev_detail,
    output logic                         have_event,
    output logic                         evt_notify,
    output logic                         q_overflow
);
    localparam int NW = 3;

    logic [1:0]       tbl_vld;
    ev_rec_t [1:0]    tbl_rec;
    logic [NW-1:0]    q_vld;
    ev_rec_t [NW-1:0] q_rec;
    ev_rec_t          q_out;

    pfe_slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .plug_vld   (plug_vld),
        .plug_slot  (plug_slot),
        .unplug_vld (unplug_vld),
        .unplug_slot(unplug_slot),
        .cmd_vld    (cmd_vld),
        .cmd_cfg    (cmd_cfg),
        .cmd_fid    (cmd_fid),
        .rsp_vld    (rsp_vld),
        .rsp_code   (rsp_code),
        .idx_sel    (idx_sel),
        .idx_found  (idx_found),
        .idx_fid    (idx_fid),
        .idx_fh     (idx_fh),
        .idx_cfg    (idx_cfg),
        .ev_vld     (tbl_vld),
        .ev_rec     (tbl_rec)
    );

    // Assemble the three write ports in their fixed priority order.
    always_comb begin
        q_vld          = {err_vld, tbl_vld};
        q_rec[0]       = tbl_rec[0];
        q_rec[1]       = tbl_rec[1];
        q_rec[2].code  = CODE_ERR;
        q_rec[2].qual  = err_qual;
        q_rec[2].fh    = err_fh;
        q_rec[2].fid   = err_fid;
        q_rec[2].addr  = err_addr;
        q_rec[2].detail = err_detail;
    end

    pfe_event_queue #(.DEPTH(Q_DEPTH), .NW(NW)) u_q (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (q_vld),
        .in_rec     (q_rec),
        .pop_req    (pop_req),
        .pop_ack    (pop_ack),
        .pop_status (pop_status),
        .out_rec    (q_out),
        .have_event (have_event),
        .notify     (evt_notify),
        .overflow   (q_overflow)
    );

    assign ev_code   = q_out.code;
    assign ev_qual   = q_out.qual;
    assign ev_fh     = q_out.fh;
    assign ev_fid    = q_out.fid;
    assign ev_addr   = q_out.addr;
    assign ev_detail = q_out.detail;
endmodule

// File: tb/sim_pci_func_evt_mgr.sv
`timescale 1ns/1ps
module sim_pci_func_evt_mgr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        plug_vld = 0, unplug_vld = 0, cmd_vld = 0, cmd_cfg = 0, err_vld = 0, pop_req = 0;
    logic [4:0]  plug_slot = 0, unplug_slot = 0;
    logic [31:0] cmd_fid = 0, err_fh = 0, err_fid = 0, err_detail = 0;
    logic [15:0] err_qual = 0;
    logic [63:0] err_addr = 0;
    logic [5:0]  idx_sel = 0;
    logic        rsp_vld, idx_found, idx_cfg, pop_ack, pop_status, have_event, evt_notify, q_overflow;
    logic [1:0]  rsp_code, ev_code;
    logic [31:0] idx_fid, idx_fh, ev_fh, ev_fid, ev_detail;
    logic [15:0] ev_qual;
    logic [63:0] ev_addr;

    always #2 clk = ~clk;

    pci_func_evt_mgr u0 (
        .clk(clk), .rst_n(rst_n),
        .plug_vld(plug_vld), .plug_slot(plug_slot),
        .unplug_vld(unplug_vld), .unplug_slot(unplug_slot),
        .cmd_vld(cmd_vld), .cmd_cfg(cmd_cfg), .cmd_fid(cmd_fid),
        .rsp_vld(rsp_vld), .rsp_code(rsp_code),
        .err_vld(err_vld), .err_qual(err_qual), .err_fh(err_fh), .err_fid(err_fid),
        .err_addr(err_addr), .err_detail(err_detail),
        .idx_sel(idx_sel), .idx_found(idx_found), .idx_fid(idx_fid), .idx_fh(idx_fh),
        .idx_cfg(idx_cfg),
        .pop_req(pop_req), .pop_ack(pop_ack), .pop_status(pop_status),
        .ev_code(ev_code), .ev_qual(ev_qual), .ev_fh(ev_fh), .ev_fid(ev_fid),
        .ev_addr(ev_addr), .ev_detail(ev_detail),
        .have_event(have_event), .evt_notify(evt_notify), .q_overflow(q_overflow)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // Reference model state
    bit          m_occ [32];
    bit          m_cfg [32];
    logic [1:0]  mq_code [16];
    logic [15:0] mq_qual [16];
    logic [31:0] mq_fh [16], mq_fid [16], mq_det [16];
    logic [63:0] mq_addr [16];
    int          m_head, m_cnt, m_used;
    bit          m_ovf;

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fh_of(int s);
        return 32'(s) | 32'h8000_0000;
    endfunction

    task automatic mpush(logic [1:0] c, logic [15:0] q, logic [31:0] h, logic [31:0] f,
                         logic [63:0] a, logic [31:0] d);
        int w;
        if (m_used < 16) begin
            w = (m_head + m_used) % 16;
            mq_code[w] = c; mq_qual[w] = q; mq_fh[w] = h; mq_fid[w] = f;
            mq_addr[w] = (c == 2'd1) ? a : 64'd0;
            mq_det[w]  = (c == 2'd1) ? d : 32'd0;
            m_used++;
        end else begin
            m_ovf = 1;
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) begin m_occ[i] = 0; m_cfg[i] = 0; end
        m_head = 0; m_cnt = 0; m_ovf = 0;
    endtask

    // One clock: inputs already driven at a negedge; model, edge, then check.
    task automatic cyc(string tag);
        bit          e_take, e_pop, e_cmd;
        logic [1:0]  e_rsp, e_code;
        logic [15:0] e_qual;
        logic [31:0] e_fh, e_fid, e_det;
        logic [63:0] e_addr;
        int          pre, s, hitn;
        e_pop = pop_req; e_cmd = cmd_vld;
        e_take = pop_req && m_cnt > 0;
        e_code = 0; e_qual = 0; e_fh = 0; e_fid = 0; e_addr = 0; e_det = 0;
        if (e_take) begin
            e_code = mq_code[m_head]; e_qual = mq_qual[m_head]; e_fh = mq_fh[m_head];
            e_fid = mq_fid[m_head]; e_addr = mq_addr[m_head]; e_det = mq_det[m_head];
        end
        pre = m_cnt; m_used = m_cnt;
        if (plug_vld) begin
            s = plug_slot;
            mpush(2, 16'h0302, fh_of(s), 32'(s), 0, 0);
            mpush(2, 16'h0301, fh_of(s), 32'(s), 0, 0);
        end else if (unplug_vld) begin
            s = unplug_slot;
            if (m_cfg[s]) mpush(2, 16'h0304, m_occ[s] ? fh_of(s) : 0, m_occ[s] ? 32'(s) : 0, 0, 0);
            mpush(2, 16'h0308, m_occ[s] ? fh_of(s) : 0, m_occ[s] ? 32'(s) : 0, 0, 0);
        end
        if (err_vld) mpush(1, err_qual, err_fh, err_fid, err_addr, err_detail);
        e_rsp = 0;
        if (cmd_vld) begin
            hitn = (cmd_fid < 32 && m_occ[cmd_fid[4:0]]) ? 1 : 0;
            if (hitn == 0) e_rsp = 2;
            else if (m_cfg[cmd_fid[4:0]] == cmd_cfg) e_rsp = 1;
            else m_cfg[cmd_fid[4:0]] = cmd_cfg;
        end
        if (plug_vld) begin
            m_occ[plug_slot] = 1; m_cfg[plug_slot] = 1;
        end else if (unplug_vld) begin
            m_occ[unplug_slot] = 0; m_cfg[unplug_slot] = 0;
        end
        if (e_take) m_head = (m_head + 1) % 16;
        m_cnt = m_used - (e_take ? 1 : 0);
        @(posedge clk);
        @(negedge clk);
        plug_vld = 0; unplug_vld = 0; cmd_vld = 0; err_vld = 0; pop_req = 0;
        chk({"R11 notify ", tag}, evt_notify, (m_used > pre) ? 1 : 0);
        chk({"R11 have_event ", tag}, have_event, (m_cnt > 0) ? 1 : 0);
        chk({"R10 overflow ", tag}, q_overflow, m_ovf);
        chk({"R8 pop_ack ", tag}, pop_ack, e_pop);
        if (e_pop) begin
            chk({"R8 pop_status ", tag}, pop_status, e_take ? 0 : 1);
            chk({"R7 code ", tag}, ev_code, e_code);
            chk({"R7 qual ", tag}, ev_qual, e_qual);
            chk({"R7 fh ", tag}, ev_fh, e_fh);
            chk({"R7 fid ", tag}, ev_fid, e_fid);
            chk({"R9 addr ", tag}, ev_addr, e_addr);
            chk({"R9 detail ", tag}, ev_detail, e_det);
        end
        chk({"R6 rsp_vld ", tag}, rsp_vld, e_cmd);
        if (e_cmd) chk({"R6 rsp_code ", tag}, rsp_code, e_rsp);
    endtask

    // Check the index port against the model for one index.
    task automatic idx_check(int n, string tag);
        int seen = 0;
        int hit = -1;
        idx_sel = 6'(n);
        #1;
        for (int i = 0; i < 32; i++) begin
            if (m_occ[i]) begin
                if (seen == n && hit < 0) hit = i;
                seen++;
            end
        end
        chk({"R5 found ", tag}, idx_found, (hit >= 0) ? 1 : 0);
        chk({"R2 fid ", tag}, idx_fid, (hit >= 0) ? 32'(hit) : 0);
        chk({"R2 fh ", tag}, idx_fh, (hit >= 0) ? fh_of(hit) : 0);
        chk({"R6 cfg ", tag}, idx_cfg, (hit >= 0) ? m_cfg[hit] : 0);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        chk("R1 have_event", have_event, 0);
        chk("R1 overflow", q_overflow, 0);
        chk("R1 notify", evt_notify, 0);
        chk("R1 pop_ack", pop_ack, 0);
        chk("R1 rsp_vld", rsp_vld, 0);
        idx_check(0, "R1 reset");
    endtask

    task automatic drain(string tag);
        while (m_cnt > 0) begin pop_req = 1; cyc(tag); end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        @(negedge clk);
        do_reset();
        pop_req = 1; cyc("R8 empty pop");
        plug_vld = 1; plug_slot = 5; cyc("R3 plug5");
        idx_check(0, "R2 slot5");
        chk("R2 handle bit31", idx_fh, 32'h8000_0005);
        pop_req = 1; cyc("R3 first");
        chk("R3 first qual", ev_qual, 16'h0302);
        pop_req = 1; cyc("R3 second");
        chk("R3 second qual", ev_qual, 16'h0301);
        plug_vld = 1; plug_slot = 3; cyc("plug3");
        plug_vld = 1; plug_slot = 9; cyc("plug9");
        cmd_vld = 1; cmd_cfg = 1; cmd_fid = 3; cyc("R6 noop");
        chk("R6 noop code", rsp_code, 2'd1);
        cmd_vld = 1; cmd_cfg = 0; cmd_fid = 3; cyc("R6 done");
        chk("R6 done code", rsp_code, 2'd0);
        cmd_vld = 1; cmd_cfg = 0; cmd_fid = 7; cyc("R6 unknown");
        chk("R6 unknown code", rsp_code, 2'd2);
        cmd_vld = 1; cmd_cfg = 1; cmd_fid = 32'h0000_0103; cyc("R6 large id");
        for (int n = 0; n < 4; n++) idx_check(n, "R5 directed");
        drain("R3 drain");
        unplug_vld = 1; unplug_slot = 3; cyc("R4 unplug unconfigured");
        pop_req = 1; cyc("R4 single");
        chk("R4 single qual", ev_qual, 16'h0308);
        chk("R4 single empty", have_event, 0);
        unplug_vld = 1; unplug_slot = 5; cyc("R4 unplug configured");
        pop_req = 1; cyc("R4 pair first");
        chk("R4 pair first qual", ev_qual, 16'h0304);
        pop_req = 1; cyc("R4 pair second");
        chk("R4 pair second qual", ev_qual, 16'h0308);
        idx_check(0, "R4 after unplug");
        plug_vld = 1; plug_slot = 7; err_vld = 1; err_qual = 16'h00AA; err_fh = 32'h1234;
        err_fid = 32'h77; err_addr = 64'hDEAD_BEEF_0000_1000; err_detail = 32'h5; cyc("R7 same cycle");
        drain("R7 order");
        for (int i = 0; i < 20; i++) begin
            err_vld = 1; err_qual = 16'(i); err_fid = 32'(i); err_addr = 64'(i) << 12;
            cyc("R10 fill");
        end
        chk("R10 sticky set", q_overflow, 1);
        drain("R10 drain");
        chk("R10 sticky after drain", q_overflow, 1);
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 9);
            if (r < 2) begin plug_vld = 1; plug_slot = 5'($urandom_range(0, 31)); end
            else if (r < 4) begin unplug_vld = 1; unplug_slot = 5'($urandom_range(0, 31)); end
            if (r == 9) begin plug_vld = 1; unplug_vld = 1; end
            if ($urandom_range(0, 2) == 0) begin
                cmd_vld = 1; cmd_cfg = 1'($urandom_range(0, 1)); cmd_fid = 32'($urandom_range(0, 40));
            end
            if ($urandom_range(0, 2) == 0) begin
                err_vld = 1; err_qual = 16'($urandom); err_fh = $urandom; err_fid = $urandom;
                err_addr = {$urandom, $urandom}; err_detail = $urandom;
            end
            pop_req = 1'($urandom_range(0, 1));
            cyc("random");
            idx_check($urandom_range(0, 33), "random");
        end
        drain("random drain");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule